// File: doc/BRIEF.md
# Virtually Tagged Cache with Process ID

This block is a direct-mapped data cache that is looked up with the virtual word address from the core, with no translation in front of it. Each line holds one data word, its virtual tag and the identifier of the process that filled it. A lookup hits only when the line is valid and both the virtual tag and the process identifier agree with the request. Two processes that use the same virtual address therefore share one line slot but never see each other's data. They evict each other instead.

Read misses fetch the word over a simple request/acknowledge memory port and install it under the requesting process. Writes always go through to memory. A write that hits also updates the cached word, and a write that misses leaves the cache unchanged. When the operating system retires a process identifier, it raises a purge command with that identifier. The cache then walks every line, one per cycle, and drops the lines owned by that process, so a later owner of the identifier cannot hit stale data. Lookups are held off while the walk runs.

Top module: `vtc_cache`

## Requirements
- R1: After reset every line is invalid, `cpu_ready_o` is high, `busy_o`, `mem_req_o` and `cpu_rvalid_o` are low, and the first read of any address misses.
- R2: The line index is the low log2(LINES) bits of the word address `cpu_addr_i`, and the tag is the remaining upper bits. Addresses with equal index and different tag evict each other, and addresses with different index do not interact.
- R3: A read accepted on a clock edge hits when the indexed line is valid and its stored tag and process ID equal the request's. On a hit, `cpu_rvalid_o` is high in the following cycle with the cached word, and no memory request is made.
- R4: A read miss raises `mem_req_o` with `mem_we_o` low and `mem_addr_o` equal to the requested word address in the cycle after acceptance, and holds all three until the edge where `mem_ack_i` is high. On that edge the line is filled with the tag, `mem_rdata_i` and the requester's process ID, and `cpu_rvalid_o` is high in the next cycle with `mem_rdata_i`.
- R5: A read with the same virtual address but a different process ID misses, and its refill replaces the line, so the previous owner misses next.
- R6: Every accepted write raises `mem_req_o` and `mem_we_o` with the write's address and data until `mem_ack_i`. On a hit the cached word takes the new data; on a miss no line is allocated.
- R7: `flush_i` accepted while idle keeps `busy_o` high for exactly LINES cycles. The walk invalidates only the lines whose stored process ID equals `flush_pid_i` as sampled at acceptance, and lines of other processes keep hitting.
- R8: `cpu_ready_o` is low whenever a refill, a write or a walk is in progress, or while `flush_i` is high. A purge and a request presented together start the purge first, and the request is accepted after the walk.
- R9: Changing `flush_pid_i` during a walk does not change which lines are invalidated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Access request, held until accepted |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | ADDR_W | Virtual word address |
| cpu_wdata_i | input | DATA_W | Write data |
| cpu_pid_i | input | PID_W | Process ID of the requester |
| cpu_ready_o | output | 1 | Request is accepted on this edge when high |
| cpu_rvalid_o | output | 1 | Read data valid |
| cpu_rdata_o | output | DATA_W | Read data |
| flush_i | input | 1 | Purge-by-process command |
| flush_pid_i | input | PID_W | Process ID to purge |
| busy_o | output | 1 | Purge walk in progress |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_ack_i | input | 1 | Memory acknowledge, one cycle |
| mem_rdata_i | input | DATA_W | Memory read data, valid with acknowledge |

## Verification
The hardest case to reach from the ports is a purge that must tell apart lines of two live processes while a third identifier's line sits beside them, with the purge identifier moving during the walk. The stimulus first fills neighbouring lines under alternating process IDs and then purges one of them. It then probes every line and counts memory reads to separate hits from misses. A second purge changes `flush_pid_i` right after `busy_o` rises. A purge raised together with a pending read shows the ordering between the two. A long random phase then mixes reads, writes and purges over a few processes and a small address window. A behavioural model checks ready, busy, the memory request fields and the read data on every cycle.

// File: rtl/vtc_pkg.sv
package vtc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_REFILL = 2'd1,
    ST_WRITE  = 2'd2,
    ST_FLUSH  = 2'd3
  } vtc_state_e;
endpackage

// File: rtl/vtc_ctrl.sv
module vtc_ctrl
  import vtc_pkg::*;
#(
  parameter int unsigned LINES = 64,
  parameter int unsigned IDX_W = $clog2(LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cpu_req_i,
  input  logic             cpu_we_i,
  input  logic             hit_i,
  input  logic             flush_i,
  input  logic             mem_ack_i,
  output vtc_state_e       state_o,
  output logic             ready_o,
  output logic             accept_o,
  output logic             flush_go_o,
  output logic [IDX_W-1:0] walk_idx_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINES - 1);

  vtc_state_e       state_q;
  logic [IDX_W-1:0] walk_q;

  // purge wins over a simultaneous lookup
  assign ready_o    = (state_q == ST_IDLE) && !flush_i;
  assign accept_o   = ready_o && cpu_req_i;
  assign flush_go_o = (state_q == ST_IDLE) && flush_i;
  assign state_o    = state_q;
  assign walk_idx_o = walk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      walk_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (flush_i) begin
            state_q <= ST_FLUSH;
            walk_q  <= '0;
          end else if (cpu_req_i) begin
            if (cpu_we_i)    state_q <= ST_WRITE;
            else if (!hit_i) state_q <= ST_REFILL;
          end
        end
        ST_REFILL, ST_WRITE: begin
          if (mem_ack_i) state_q <= ST_IDLE;
        end
        ST_FLUSH: begin
          if (walk_q == LAST_IDX) state_q <= ST_IDLE;
          walk_q <= walk_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vtc_tag_store.sv
module vtc_tag_store #(
  parameter int unsigned LINES = 64,
  parameter int unsigned TAG_W = 24,
  parameter int unsigned PID_W = 8,
  parameter int unsigned IDX_W = $clog2(LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] lk_idx_i,
  input  logic [TAG_W-1:0] lk_tag_i,
  input  logic [PID_W-1:0] lk_pid_i,
  output logic             hit_o,
  input  logic             fill_i,
  input  logic [IDX_W-1:0] fill_idx_i,
  input  logic [TAG_W-1:0] fill_tag_i,
  input  logic [PID_W-1:0] fill_pid_i,
  input  logic             inv_i,
  input  logic [IDX_W-1:0] inv_idx_i,
  input  logic [PID_W-1:0] inv_pid_i
);
  logic [LINES-1:0] valid_q, valid_d;
  logic [TAG_W-1:0] tag_q [LINES];
  logic [PID_W-1:0] pid_q [LINES];
  logic [LINES-1:0] own_match;

  // per-line owner compare against the purge ID
  for (genvar g = 0; g < LINES; g++) begin : g_own
    assign own_match[g] = valid_q[g] && (pid_q[g] == inv_pid_i);
  end

  assign hit_o = valid_q[lk_idx_i] && (tag_q[lk_idx_i] == lk_tag_i) &&
                 (pid_q[lk_idx_i] == lk_pid_i);

  always_comb begin
    valid_d = valid_q;
    if (inv_i && own_match[inv_idx_i]) valid_d[inv_idx_i] = 1'b0;
    if (fill_i) valid_d[fill_idx_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= '0;
    else         valid_q <= valid_d;
  end

  always_ff @(posedge clk_i) begin
    if (fill_i) begin
      tag_q[fill_idx_i] <= fill_tag_i;
      pid_q[fill_idx_i] <= fill_pid_i;
    end
  end
endmodule

// File: rtl/vtc_data_store.sv
module vtc_data_store #(
  parameter int unsigned LINES  = 64,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = $clog2(LINES)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] word_q [LINES];

  always_ff @(posedge clk_i) begin
    if (we_i) word_q[widx_i] <= wdata_i;
  end

  assign rdata_o = word_q[ridx_i];
endmodule

// File: rtl/vtc_cache.sv
module vtc_cache
  import vtc_pkg::*;
#(
  parameter int unsigned ADDR_W = 30,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PID_W  = 8,
  parameter int unsigned LINES  = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  input  logic [PID_W-1:0]  cpu_pid_i,
  output logic              cpu_ready_o,
  output logic              cpu_rvalid_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  input  logic              flush_i,
  input  logic [PID_W-1:0]  flush_pid_i,
  output logic              busy_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam int unsigned IDX_W = $clog2(LINES);
  localparam int unsigned TAG_W = ADDR_W - IDX_W;

  vtc_state_e        state;
  logic              ready, accept, flush_go, hit;
  logic [IDX_W-1:0]  walk_idx;
  logic [DATA_W-1:0] line_word;
  logic              read_hit, write_hit, refill_done;

  logic [ADDR_W-1:0] addr_q;
  logic [PID_W-1:0]  pid_q, fpid_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              rvalid_q;

  wire [IDX_W-1:0] cpu_idx = cpu_addr_i[IDX_W-1:0];
  wire [TAG_W-1:0] cpu_tag = cpu_addr_i[ADDR_W-1:IDX_W];
  wire [IDX_W-1:0] q_idx   = addr_q[IDX_W-1:0];
  wire [TAG_W-1:0] q_tag   = addr_q[ADDR_W-1:IDX_W];

  assign read_hit    = accept && !cpu_we_i && hit;
  assign write_hit   = accept && cpu_we_i && hit;
  assign refill_done = (state == ST_REFILL) && mem_ack_i;

  vtc_ctrl #(.LINES(LINES), .IDX_W(IDX_W)) ctrl_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cpu_req_i (cpu_req_i),
    .cpu_we_i  (cpu_we_i),
    .hit_i     (hit),
    .flush_i   (flush_i),
    .mem_ack_i (mem_ack_i),
    .state_o   (state),
    .ready_o   (ready),
    .accept_o  (accept),
    .flush_go_o(flush_go),
    .walk_idx_o(walk_idx)
  );

  vtc_tag_store #(.LINES(LINES), .TAG_W(TAG_W), .PID_W(PID_W), .IDX_W(IDX_W)) tags_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lk_idx_i  (cpu_idx),
    .lk_tag_i  (cpu_tag),
    .lk_pid_i  (cpu_pid_i),
    .hit_o     (hit),
    .fill_i    (refill_done),
    .fill_idx_i(q_idx),
    .fill_tag_i(q_tag),
    .fill_pid_i(pid_q),
    .inv_i     (state == ST_FLUSH),
    .inv_idx_i (walk_idx),
    .inv_pid_i (fpid_q)
  );

  vtc_data_store #(.LINES(LINES), .DATA_W(DATA_W), .IDX_W(IDX_W)) data_i (
    .clk_i  (clk_i),
    .we_i   (write_hit || refill_done),
    .widx_i (refill_done ? q_idx : cpu_idx),
    .wdata_i(refill_done ? mem_rdata_i : cpu_wdata_i),
    .ridx_i (cpu_idx),
    .rdata_o(line_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      pid_q    <= '0;
      wdata_q  <= '0;
      fpid_q   <= '0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      if (accept) begin
        addr_q  <= cpu_addr_i;
        pid_q   <= cpu_pid_i;
        wdata_q <= cpu_wdata_i;
      end
      if (flush_go) fpid_q <= flush_pid_i;
      rvalid_q <= read_hit || refill_done;
      if (read_hit)         rdata_q <= line_word;
      else if (refill_done) rdata_q <= mem_rdata_i;
    end
  end

  assign cpu_ready_o  = ready;
  assign cpu_rvalid_o = rvalid_q;
  assign cpu_rdata_o  = rdata_q;
  assign busy_o       = (state == ST_FLUSH);
  assign mem_req_o    = (state == ST_REFILL) || (state == ST_WRITE);
  assign mem_we_o     = (state == ST_WRITE);
  assign mem_addr_o   = addr_q;
  assign mem_wdata_o  = wdata_q;
endmodule

// File: rtl/vtc_cache_chk.sv
module vtc_cache_chk #(
  parameter int unsigned ADDR_W = 30,
  parameter int unsigned LINES  = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_req_i,
  input logic              cpu_we_i,
  input logic              cpu_ready_o,
  input logic              cpu_rvalid_o,
  input logic              flush_i,
  input logic              busy_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic              mem_ack_i,
  input logic [ADDR_W-1:0] mem_addr_o
);
  localparam int unsigned CW = $clog2(LINES + 1) + 1;
  logic [CW-1:0] busy_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_cnt_q <= '0;
    else if (busy_o) busy_cnt_q <= busy_cnt_q + 1'b1;
    else             busy_cnt_q <= '0;
  end

  a_r8_no_accept_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !cpu_ready_o);

  a_r8_no_accept_mem: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !cpu_ready_o);

  a_r4_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));

  a_r3_rvalid_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rvalid_o |-> (!mem_req_o && !busy_o));

  a_r4_read_progress: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_i && cpu_ready_o && !cpu_we_i) |=> (cpu_rvalid_o || (mem_req_o && !mem_we_o)));

  a_r6_write_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_i && cpu_ready_o && cpu_we_i) |=> (mem_req_o && mem_we_o));

  a_r7_busy_from_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(flush_i));

  a_r7_busy_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (busy_cnt_q == CW'(LINES)));

  a_r7_busy_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (busy_cnt_q < CW'(LINES)));
endmodule

bind vtc_cache vtc_cache_chk #(.ADDR_W(ADDR_W), .LINES(LINES)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cpu_req_i   (cpu_req_i),
  .cpu_we_i    (cpu_we_i),
  .cpu_ready_o (cpu_ready_o),
  .cpu_rvalid_o(cpu_rvalid_o),
  .flush_i     (flush_i),
  .busy_o      (busy_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_ack_i   (mem_ack_i),
  .mem_addr_o  (mem_addr_o)
);

// File: tb/vtc_cache_tb_top.sv
`timescale 1ns/1ps
module vtc_cache_tb_top;
  localparam int AW = 30;
  localparam int DW = 32;
  localparam int PW = 8;
  localparam int NL = 64;

  logic clk_i = 1'b0;
  always #4 clk_i = ~clk_i;

  logic          rst_ni = 1'b0;
  logic          cpu_req_i = 0, cpu_we_i = 0;
  logic [AW-1:0] cpu_addr_i = '0;
  logic [DW-1:0] cpu_wdata_i = '0;
  logic [PW-1:0] cpu_pid_i = '0;
  logic          cpu_ready_o, cpu_rvalid_o;
  logic [DW-1:0] cpu_rdata_o;
  logic          flush_i = 0;
  logic [PW-1:0] flush_pid_i = '0;
  logic          busy_o, mem_req_o, mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_wdata_o;
  logic          mem_ack_i = 0;
  logic [DW-1:0] mem_rdata_i = '0;

  vtc_cache #(.ADDR_W(AW), .DATA_W(DW), .PID_W(PW), .LINES(NL)) dut_i (
    .clk_i, .rst_ni, .cpu_req_i, .cpu_we_i, .cpu_addr_i, .cpu_wdata_i, .cpu_pid_i,
    .cpu_ready_o, .cpu_rvalid_o, .cpu_rdata_o, .flush_i, .flush_pid_i, .busy_o,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_ack_i, .mem_rdata_i
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // memory model
  logic [DW-1:0] mem_store [logic [AW-1:0]];
  int rd_cnt = 0, wait_cnt = 0, lat = 0;

  function automatic logic [DW-1:0] mem_rd(input logic [AW-1:0] a);
    if (mem_store.exists(a)) return mem_store[a];
    return {a[15:0], ~a[15:0]} ^ 32'h5A5A_0F0F;
  endfunction

  always @(posedge clk_i) begin
    #1;
    if (mem_ack_i) mem_ack_i = 1'b0;
    else if (mem_req_o) begin
      if (wait_cnt == 0) begin
        mem_ack_i = 1'b1;
        if (mem_we_o) mem_store[mem_addr_o] = mem_wdata_o;
        else begin
          mem_rdata_i = mem_rd(mem_addr_o);
          rd_cnt++;
        end
        lat = (lat + 1) % 3;
        wait_cnt = lat;
      end else wait_cnt--;
    end
  end

  // reference model: 0 idle, 1 refill, 2 write, 3 purge
  bit            mv [NL];
  logic [AW-1:0] mt [NL];
  logic [PW-1:0] mp [NL];
  logic [DW-1:0] md [NL];
  int            m_state = 0, m_cnt = 0;
  logic [AW-1:0] m_addr;
  logic [PW-1:0] m_pid, m_fpid;
  logic [DW-1:0] m_wdata, exp_rd;
  bit            exp_rv = 0;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NL; i++) mv[i] = 0;
      m_state = 0;
      exp_rv  = 0;
    end else begin
      exp_rv = 0;
      case (m_state)
        0: begin
          if (flush_i) begin
            m_state = 3; m_cnt = 0; m_fpid = flush_pid_i;
          end else if (cpu_req_i) begin
            int ix;
            bit h;
            ix = int'(cpu_addr_i % NL);
            h  = mv[ix] && (mt[ix] / NL == cpu_addr_i / NL) && (mp[ix] == cpu_pid_i);
            m_addr = cpu_addr_i; m_pid = cpu_pid_i; m_wdata = cpu_wdata_i;
            if (cpu_we_i) begin
              if (h) md[ix] = cpu_wdata_i;
              m_state = 2;
            end else if (h) begin
              exp_rv = 1; exp_rd = md[ix];
            end else m_state = 1;
          end
        end
        1: if (mem_ack_i) begin
          int ix;
          ix = int'(m_addr % NL);
          mv[ix] = 1; mt[ix] = m_addr; mp[ix] = m_pid; md[ix] = mem_rdata_i;
          exp_rv = 1; exp_rd = mem_rdata_i;
          m_state = 0;
        end
        2: if (mem_ack_i) m_state = 0;
        default: begin
          if (mv[m_cnt] && mp[m_cnt] == m_fpid) mv[m_cnt] = 0;
          if (m_cnt == NL - 1) m_state = 0;
          m_cnt++;
        end
      endcase
    end
  end

  int busy_cycles = 0;

  always @(negedge clk_i) begin
    if (rst_ni && !finished) begin
      if (busy_o) busy_cycles++;
      chk(cpu_ready_o == (m_state == 0 && !flush_i), "R8", "cpu_ready_o",
          32'(cpu_ready_o), 32'(m_state == 0 && !flush_i));
      chk(busy_o == (m_state == 3), "R7", "busy_o", 32'(busy_o), 32'(m_state == 3));
      chk(mem_req_o == (m_state == 1 || m_state == 2), "R4", "mem_req_o",
          32'(mem_req_o), 32'(m_state == 1 || m_state == 2));
      if (m_state == 1)
        chk(mem_addr_o == m_addr && !mem_we_o, "R4", "refill address",
            32'(mem_addr_o), 32'(m_addr));
      if (m_state == 2) begin
        chk(mem_addr_o == m_addr && mem_we_o, "R6", "write address",
            32'(mem_addr_o), 32'(m_addr));
        chk(mem_wdata_o == m_wdata, "R6", "write data", mem_wdata_o, m_wdata);
      end
      chk(cpu_rvalid_o == exp_rv, "R3", "cpu_rvalid_o", 32'(cpu_rvalid_o), 32'(exp_rv));
      if (exp_rv) chk(cpu_rdata_o == exp_rd, "R3", "cpu_rdata_o", cpu_rdata_o, exp_rd);
    end
  end

  task automatic wait_idle();
    do @(negedge clk_i); while (m_state != 0);
  endtask

  task automatic op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                    input logic [PW-1:0] p);
    @(posedge clk_i); #1;
    cpu_req_i = 1; cpu_we_i = we; cpu_addr_i = a; cpu_wdata_i = d; cpu_pid_i = p;
    do @(negedge clk_i); while (!cpu_ready_o);
    @(posedge clk_i); #1;
    cpu_req_i = 0;
    wait_idle();
  endtask

  task automatic purge(input logic [PW-1:0] p, input logic [PW-1:0] p_late);
    @(posedge clk_i); #1;
    flush_i = 1; flush_pid_i = p;
    do @(negedge clk_i); while (!busy_o);
    @(posedge clk_i); #1;
    flush_i = 0; flush_pid_i = p_late;
    wait_idle();
  endtask

  task automatic expect_reads(input int n, input string rq, input string what);
    chk(rd_cnt == n, rq, what, 32'(rd_cnt), 32'(n));
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (4) @(posedge clk_i);
    #1 rst_ni = 1;
    @(negedge clk_i);
    chk(cpu_ready_o == 1, "R1", "ready after reset", 32'(cpu_ready_o), 1);
    chk(busy_o == 0, "R1", "busy after reset", 32'(busy_o), 0);
    chk(mem_req_o == 0, "R1", "mem_req after reset", 32'(mem_req_o), 0);
    chk(cpu_rvalid_o == 0, "R1", "rvalid after reset", 32'(cpu_rvalid_o), 0);

    op(0, 30'h100, 0, 8'd1);
    expect_reads(1, "R1", "first read misses");
    op(0, 30'h100, 0, 8'd1);
    expect_reads(1, "R3", "repeat read hits");

    op(0, 30'h100, 0, 8'd2);
    expect_reads(2, "R5", "other pid misses");
    op(0, 30'h100, 0, 8'd1);
    expect_reads(3, "R5", "first pid evicted");

    op(0, 30'h140, 0, 8'd1);
    expect_reads(4, "R2", "same index new tag misses");
    op(0, 30'h141, 0, 8'd1);
    expect_reads(5, "R2", "next index misses");
    op(0, 30'h140, 0, 8'd1);
    expect_reads(5, "R2", "other index untouched");
    op(0, 30'h100, 0, 8'd1);
    expect_reads(6, "R2", "conflicting tag evicted");

    op(1, 30'h141, 32'hDEAD_BEEF, 8'd1);
    op(0, 30'h141, 0, 8'd1);
    expect_reads(6, "R6", "write hit updates line");
    op(1, 30'h2A0, 32'h1234_5678, 8'd1);
    op(0, 30'h2A0, 0, 8'd1);
    expect_reads(7, "R6", "write miss does not allocate");
    op(1, 30'h141, 32'h1111_1111, 8'd2);
    op(0, 30'h141, 0, 8'd1);
    expect_reads(7, "R6", "pid-mismatch write leaves owner line");

    for (int i = 0; i < 10; i++) op(0, 30'h300 + 30'(i), 0, (i % 2) ? 8'd3 : 8'd4);
    busy_cycles = 0;
    purge(8'd3, 8'd3);
    chk(busy_cycles == NL, "R7", "busy length", 32'(busy_cycles), 32'(NL));
    base = rd_cnt;
    for (int i = 0; i < 10; i += 2) op(0, 30'h300 + 30'(i), 0, 8'd4);
    expect_reads(base, "R7", "other pid lines survive");
    for (int i = 1; i < 10; i += 2) op(0, 30'h300 + 30'(i), 0, 8'd3);
    expect_reads(base + 5, "R7", "purged pid lines miss");

    op(0, 30'h380, 0, 8'd5);
    op(0, 30'h381, 0, 8'd4);
    base = rd_cnt;
    purge(8'd4, 8'd5);
    op(0, 30'h380, 0, 8'd5);
    expect_reads(base, "R9", "late purge id ignored");
    op(0, 30'h381, 0, 8'd4);
    expect_reads(base + 1, "R9", "latched purge id applied");

    base = rd_cnt;
    @(posedge clk_i); #1;
    flush_i = 1; flush_pid_i = 8'd9;
    cpu_req_i = 1; cpu_we_i = 0; cpu_addr_i = 30'h380; cpu_pid_i = 8'd5;
    @(negedge clk_i);
    chk(cpu_ready_o == 0, "R8", "purge blocks request", 32'(cpu_ready_o), 0);
    do @(negedge clk_i); while (!busy_o);
    @(posedge clk_i); #1;
    flush_i = 0;
    do @(negedge clk_i); while (!cpu_ready_o);
    chk(busy_cycles > 0 && busy_o == 0, "R8", "request waits for walk", 32'(busy_o), 0);
    @(posedge clk_i); #1;
    cpu_req_i = 0;
    wait_idle();
    expect_reads(base, "R8", "deferred request hits");

    for (int n = 0; n < 400; n++) begin
      int r;
      r = $urandom_range(0, 24);
      if (r == 0) purge(8'($urandom_range(0, 3)), 8'($urandom_range(0, 3)));
      else op(r < 7, 30'h400 + 30'($urandom_range(0, 127)), $urandom,
              8'($urandom_range(0, 3)));
    end
    wait_idle();

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule